// File: doc/BRIEF.md
# E1 Frame and Signaling Multiframe Aligner

This block takes an E1 line as a serial bit stream, qualified by a bit-clock enable. Each frame is 32 timeslots of 8 bits. Every bit offset of the 256-bit frame is scanned for the frame alignment word. A candidate offset is trusted only after a three-stage check that spans three frames. Once basic alignment is held, the block labels every received bit with its bit and timeslot position. It then looks in timeslot 16 for the all-zero nibble that marks the start of a 16-frame signaling multiframe, and numbers the frames within that multiframe.

Both status flags are active low. `sync_n` reports basic frame alignment. `mfsync_n` reports signaling multiframe alignment. Downstream logic uses the counters to pick timeslots and signaling frames out of the stream. Once basic alignment is declared it is held until reset.

Top module: `e1_frame_aligner`

## Requirements
- R1: While `rst_n` is low, `bit_cnt`, `ts_cnt` and `frm_cnt` are 0 and `sync_n` and `mfsync_n` are 1.
- R2: A candidate frame alignment word (the last seven bits of an octet equal to 0011011) is rejected, and the hunt resumes, when the second bit of the octet at that position one frame later is 0. A stream that repeats this never drives `sync_n` low.
- R3: `sync_n` goes low right after the last bit of a second frame alignment word, at the same offset two frames after the first. The octet between them must have its second bit set to 1. `sync_n` is 1 on the bit before.
- R4: A candidate that passes the second-bit test but is not followed by a correct alignment word two frames after the first gives no lock.
- R5: While `sync_n` is low, `{ts_cnt, bit_cnt}` gives the frame position of the most recently accepted bit. `bit_cnt` 0 is the first bit received of an octet, and `ts_cnt` 0 is the timeslot that carries the alignment word.
- R6: While `sync_n` is high, `mfsync_n` stays 1, even if timeslot 16 carries 0000.
- R7: With `sync_n` low and no multiframe lock, the first timeslot 16 whose first four bits are 0000 drives `mfsync_n` low right after its fourth bit. `frm_cnt` becomes 0 in that frame.
- R8: While basic alignment is held, `frm_cnt` advances by one, modulo 16, on the first bit of each frame.
- R9: While locked to the multiframe, a single frame 0 whose timeslot 16 nibble is not 0000 leaves `mfsync_n` low.
- R10: Two consecutive multiframes with a wrong frame-0 nibble drive `mfsync_n` high right after the fourth timeslot 16 bit of the second one. The next 0000 nibble re-locks the multiframe.
- R11: A cycle with `bit_en` low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Accept `rx_bit` this cycle |
| rx_bit | input | 1 | Received line bit |
| bit_cnt | output | 3 | Bit position of the last accepted bit within its octet |
| ts_cnt | output | 5 | Timeslot of the last accepted bit |
| frm_cnt | output | 4 | Frame number within the signaling multiframe |
| sync_n | output | 1 | Low while basic frame alignment is held |
| mfsync_n | output | 1 | Low while signaling multiframe alignment is held |

## Verification
A wrong hunt state shows at `sync_n`. The flag either falls on a bit other than the last bit of the confirming alignment word, or falls on a stream that must never lock. Both are visible within three frames of the first candidate. A stuck or misloaded position counter shows in `{ts_cnt, bit_cnt}` within the same frame. A multiframe state or error memory that is off moves the edge of `mfsync_n` to a different timeslot 16 nibble, so the fault surfaces within one or two multiframes (16 to 32 frames). It also leaves `frm_cnt` out of step from the next frame on.

// File: rtl/e1_align_pkg.sv
package e1_align_pkg;
  localparam int OCT_BITS_D  = 8;
  localparam int NUM_TS_D    = 32;
  localparam int MF_FRAMES_D = 16;
  localparam int FAS_LEN     = 7;
  localparam int MFAS_LEN    = 4;
  localparam int FAS_TS_D    = 0;
  localparam int SIG_TS_D    = 16;
  localparam logic [FAS_LEN-1:0] FAS_WORD = 7'b0011011;

  typedef enum logic [1:0] {
    BF_HUNT = 2'd0,
    BF_NFAS = 2'd1,
    BF_FAS2 = 2'd2,
    BF_LOCK = 2'd3
  } bf_state_t;

  typedef enum logic {
    MF_SEARCH = 1'b0,
    MF_HOLD   = 1'b1
  } mf_state_t;
endpackage

// File: rtl/e1_slot_counter.sv
module e1_slot_counter #(
  parameter int OCT_BITS = 8,
  parameter int NUM_TS   = 32,
  parameter int FAS_TS   = 0,
  parameter int SIG_TS   = 16,
  parameter int NIB_LEN  = 4,
  localparam int BIT_W   = $clog2(OCT_BITS),
  localparam int TS_W    = $clog2(NUM_TS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             load,
  output logic [BIT_W-1:0] bit_cnt,
  output logic [TS_W-1:0]  ts_cnt,
  output logic             fas_end,
  output logic             nib_end,
  output logic             frame_start
);
  localparam logic [BIT_W-1:0] BIT_MAX = BIT_W'(OCT_BITS - 1);
  localparam logic [TS_W-1:0]  TS_MAX  = TS_W'(NUM_TS - 1);
  localparam logic [TS_W-1:0]  TS_FAS  = TS_W'(FAS_TS);
  localparam logic [TS_W-1:0]  TS_SIG  = TS_W'(SIG_TS);
  localparam logic [BIT_W-1:0] BIT_NIB = BIT_W'(NIB_LEN - 1);

  logic [BIT_W-1:0] bit_q, bit_d, bit_nx;
  logic [TS_W-1:0]  ts_q, ts_d, ts_nx;

  // position the incoming bit will take
  always_comb begin
    bit_nx = (bit_q == BIT_MAX) ? '0 : bit_q + 1'b1;
    ts_nx  = ts_q;
    if (bit_q == BIT_MAX) ts_nx = (ts_q == TS_MAX) ? '0 : ts_q + 1'b1;
  end

  assign fas_end     = bit_en && (ts_nx == TS_FAS) && (bit_nx == BIT_MAX);
  assign nib_end     = bit_en && (ts_nx == TS_SIG) && (bit_nx == BIT_NIB);
  assign frame_start = bit_en && (ts_nx == '0) && (bit_nx == '0);

  always_comb begin
    bit_d = bit_q;
    ts_d  = ts_q;
    if (load) begin
      bit_d = BIT_MAX;
      ts_d  = TS_FAS;
    end else if (bit_en) begin
      bit_d = bit_nx;
      ts_d  = ts_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      ts_q  <= '0;
    end else begin
      bit_q <= bit_d;
      ts_q  <= ts_d;
    end
  end

  assign bit_cnt = bit_q;
  assign ts_cnt  = ts_q;

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !load) |=> ($stable(bit_q) && $stable(ts_q)));

  // R5
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !load && bit_q != BIT_MAX) |=> (bit_q == $past(bit_q) + 1'b1) && $stable(ts_q));

  // R5
  load_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bit_q == BIT_MAX) && (ts_q == TS_FAS));
endmodule

// File: rtl/e1_basic_framer.sv
module e1_basic_framer
  import e1_align_pkg::*;
#(
  parameter int OCT_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic                rx_bit,
  input  logic                fas_end,
  output logic                load,
  output logic                locked,
  output logic [OCT_BITS-1:0] win
);
  bf_state_t             st_q, st_d;
  logic [OCT_BITS-2:0]   sh_q, sh_d;
  logic                  fas_ok;
  logic                  nfas_b2;

  // the last octet, oldest bit in the MSB
  assign win     = {sh_q, rx_bit};
  assign fas_ok  = (win[FAS_LEN-1:0] == FAS_WORD);
  assign nfas_b2 = win[OCT_BITS-2];
  assign load    = bit_en && (st_q == BF_HUNT) && fas_ok;
  assign locked  = (st_q == BF_LOCK);

  always_comb begin
    sh_d = sh_q;
    if (bit_en) sh_d = win[OCT_BITS-2:0];
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BF_HUNT: if (bit_en && fas_ok) st_d = BF_NFAS;
      BF_NFAS: if (fas_end) st_d = nfas_b2 ? BF_FAS2 : BF_HUNT;
      BF_FAS2: if (fas_end) st_d = fas_ok ? BF_LOCK : BF_HUNT;
      default: st_d = BF_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BF_HUNT;
      sh_q <= '1;
    end else begin
      st_q <= st_d;
      sh_q <= sh_d;
    end
  end

  // R2
  nfas_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BF_NFAS && fas_end && !win[OCT_BITS-2]) |=> (st_q == BF_HUNT));

  // R3
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BF_LOCK && $past(st_q) != BF_LOCK) |-> ($past(st_q) == BF_FAS2 && $past(fas_end)));

  // R4
  fas2_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BF_FAS2 && fas_end && !fas_ok) |=> (st_q == BF_HUNT));
endmodule

// File: rtl/e1_mf_aligner.sv
module e1_mf_aligner
  import e1_align_pkg::*;
#(
  parameter int MF_FRAMES = 16,
  localparam int MF_W     = $clog2(MF_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bf_locked,
  input  logic                nib_end,
  input  logic                frame_start,
  input  logic [MFAS_LEN-1:0] nibble,
  output logic                mf_locked,
  output logic [MF_W-1:0]     frm_cnt
);
  mf_state_t        st_q, st_d;
  logic             err_q, err_d;
  logic [MF_W-1:0]  frm_q, frm_d;
  logic             nib_zero;

  assign nib_zero  = (nibble == '0);
  assign mf_locked = (st_q == MF_HOLD);
  assign frm_cnt   = frm_q;

  always_comb begin
    st_d  = st_q;
    err_d = err_q;
    frm_d = frm_q;
    if (!bf_locked) begin
      frm_d = '0;
    end else if (frame_start) begin
      frm_d = frm_q + 1'b1;
    end
    unique case (st_q)
      MF_SEARCH: begin
        if (bf_locked && nib_end && nib_zero) begin
          st_d  = MF_HOLD;
          err_d = 1'b0;
          frm_d = '0;
        end
      end
      default: begin
        if (!bf_locked) begin
          st_d = MF_SEARCH;
        end else if (nib_end && frm_q == '0) begin
          if (nib_zero) begin
            err_d = 1'b0;
          end else if (err_q) begin
            st_d  = MF_SEARCH;
            err_d = 1'b0;
          end else begin
            err_d = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MF_SEARCH;
      err_q <= 1'b0;
      frm_q <= '0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      frm_q <= frm_d;
    end
  end

  // R7
  lock_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_locked) |-> (frm_q == '0) && $past(nib_end) && $past(bf_locked));

  // R8
  frm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bf_locked && frame_start) |=> (frm_q == MF_W'($past(frm_q) + 1'b1)));

  // R9
  single_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_locked && bf_locked && nib_end && frm_q == '0 && !nib_zero && !err_q) |=> mf_locked);

  // R10
  double_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_locked && nib_end && frm_q == '0 && !nib_zero && err_q) |=> !mf_locked);
endmodule

// File: rtl/e1_frame_aligner.sv
module e1_frame_aligner
  import e1_align_pkg::*;
#(
  parameter int OCT_BITS  = OCT_BITS_D,
  parameter int NUM_TS    = NUM_TS_D,
  parameter int MF_FRAMES = MF_FRAMES_D
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bit_en,
  input  logic                           rx_bit,
  output logic [$clog2(OCT_BITS)-1:0]    bit_cnt,
  output logic [$clog2(NUM_TS)-1:0]      ts_cnt,
  output logic [$clog2(MF_FRAMES)-1:0]   frm_cnt,
  output logic                           sync_n,
  output logic                           mfsync_n
);
  logic [1:0]          rst_sync;
  logic                rst_sn;
  logic                load, fas_end, nib_end, frame_start;
  logic                bf_locked, mf_locked;
  logic [OCT_BITS-1:0] win;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  e1_slot_counter #(
    .OCT_BITS (OCT_BITS),
    .NUM_TS   (NUM_TS),
    .FAS_TS   (FAS_TS_D),
    .SIG_TS   (SIG_TS_D),
    .NIB_LEN  (MFAS_LEN)
  ) u_pos (
    .clk         (clk),
    .rst_n       (rst_sn),
    .bit_en      (bit_en),
    .load        (load),
    .bit_cnt     (bit_cnt),
    .ts_cnt      (ts_cnt),
    .fas_end     (fas_end),
    .nib_end     (nib_end),
    .frame_start (frame_start)
  );

  e1_basic_framer #(
    .OCT_BITS (OCT_BITS)
  ) u_bf (
    .clk     (clk),
    .rst_n   (rst_sn),
    .bit_en  (bit_en),
    .rx_bit  (rx_bit),
    .fas_end (fas_end),
    .load    (load),
    .locked  (bf_locked),
    .win     (win)
  );

  e1_mf_aligner #(
    .MF_FRAMES (MF_FRAMES)
  ) u_mf (
    .clk         (clk),
    .rst_n       (rst_sn),
    .bf_locked   (bf_locked),
    .nib_end     (nib_end),
    .frame_start (frame_start),
    .nibble      (win[MFAS_LEN-1:0]),
    .mf_locked   (mf_locked),
    .frm_cnt     (frm_cnt)
  );

  assign sync_n   = !bf_locked;
  assign mfsync_n = !mf_locked;

  // R6
  mf_needs_bf_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !mfsync_n |-> !sync_n);
endmodule

// File: tb/sim_e1_frame_aligner.sv
module sim_e1_frame_aligner;
  logic       clk = 1'b0;
  logic       rst_n, bit_en, rx_bit;
  logic [2:0] bit_cnt;
  logic [4:0] ts_cnt;
  logic [3:0] frm_cnt;
  logic       sync_n, mfsync_n;

  always #10 clk = ~clk;

  e1_frame_aligner u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .bit_cnt(bit_cnt), .ts_cnt(ts_cnt), .frm_cnt(frm_cnt),
    .sync_n(sync_n), .mfsync_n(mfsync_n)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // stimulus mode: 0 proper stream, 1 bad second bit after every FAS, 2 bad second FAS
  int        mode;
  int        never_mode;
  string     never_tag;
  logic [15:0] cmask;
  int        k_sync;
  bit        synced_m, mfl_m, err_m;
  int        frm_m;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 180000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<180000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] payload();
    logic [31:0] r;
    r = $urandom;
    return {1'b1, r[0], 1'b1, r[1], 1'b1, r[2], 1'b1, r[3]};
  endfunction

  function automatic logic [7:0] make_oct(int k, int ts);
    logic [31:0] r;
    if (ts == 0) begin
      r = $urandom;
      if (k % 2 == 0) return (mode == 2 && k % 4 == 2) ? 8'hBB : {r[0], 7'b0011011};
      return (mode == 1) ? 8'hBF : 8'hDF;
    end
    if (ts == 16 && (k % 16 == 0 || mode == 1))
      return cmask[(k / 16) % 16] ? 8'hAB : 8'h0B;
    return payload();
  endfunction

  task automatic send_bit(input logic b);
    logic [13:0] snap;
    rx_bit = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    if ($urandom % 4 == 0) begin
      snap = {bit_cnt, ts_cnt, frm_cnt, sync_n, mfsync_n};
      rx_bit = ~b;
      @(negedge clk);
      chk("R11 idle hold", {bit_cnt, ts_cnt, frm_cnt, sync_n, mfsync_n}, snap);
    end
  endtask

  task automatic after_bit(input int k, input int p, input logic [7:0] oct);
    string tag;
    if (never_mode) begin
      if (p == 7) chk(never_tag, sync_n, 1'b1);
      if (p == 131) chk("R6 no MF lock without basic sync", mfsync_n, 1'b1);
      return;
    end
    if (k == k_sync && p == 6) chk("R3 sync_n before confirming FAS", sync_n, 1'b1);
    if (k == k_sync && p == 7) begin
      synced_m = 1'b1;
      chk("R3 sync_n after confirming FAS", sync_n, 1'b0);
    end
    if (synced_m && p == 0) frm_m = (frm_m + 1) % 16;
    if (synced_m && p % 64 == 37) chk("R5 bit position", {ts_cnt, bit_cnt}, p);
    if (p == 130) chk("R7 mfsync_n before nibble", mfsync_n, !mfl_m);
    if (p == 131) begin
      if (!synced_m) chk("R6 mfsync_n before basic sync", mfsync_n, 1'b1);
      else begin
        tag = "R7 mfsync_n after nibble";
        if (!mfl_m) begin
          if (oct[7:4] == 4'h0) begin mfl_m = 1; err_m = 0; frm_m = 0; end
        end else if (frm_m == 0) begin
          if (oct[7:4] != 4'h0) begin
            if (err_m) begin mfl_m = 0; err_m = 0; tag = "R10 loss on second errored MF"; end
            else begin err_m = 1; tag = "R9 single errored MF keeps lock"; end
          end else err_m = 0;
        end
        chk(tag, mfsync_n, !mfl_m);
        if (mfl_m && frm_m == 0) chk("R7 frame number at lock", frm_cnt, 0);
      end
    end
    if (mfl_m && p == 200) chk("R8 frame number", frm_cnt, frm_m);
  endtask

  task automatic run(input int k1, input int o);
    logic [7:0] oct;
    for (int k = 0; k <= k1; k++)
      for (int ts = 0; ts < 32; ts++) begin
        oct = make_oct(k, ts);
        for (int b = 0; b < 8; b++) begin
          if (k == 0 && ts * 8 + b < o) continue;
          send_bit(oct[7-b]);
          after_bit(k, ts * 8 + b, oct);
        end
      end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset bit_cnt", bit_cnt, 0);
    chk("R1 reset ts_cnt", ts_cnt, 0);
    chk("R1 reset frm_cnt", frm_cnt, 0);
    chk("R1 reset sync_n", sync_n, 1);
    chk("R1 reset mfsync_n", mfsync_n, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    synced_m = 0; mfl_m = 0; err_m = 0; frm_m = 0;
  endtask

  initial begin
    int o;
    void'($urandom(32'd4242));
    // proper stream, random start, MF error patterns
    do_reset();
    mode = 0; never_mode = 0;
    cmask = 16'h0068; // MF 3 alone, then MF 5 and 6 in a row
    o = $urandom % 256;
    k_sync = (o <= 1) ? 2 : 4;
    run(127, o);
    // directed and random start offsets
    for (int i = 0; i < 4; i++) begin
      do_reset();
      mode = 0; never_mode = 0; cmask = 16'h0000;
      o = (i == 0) ? 1 : (i == 1) ? 2 : int'($urandom % 256);
      k_sync = (o <= 1) ? 2 : 4;
      run(19, o);
    end
    // R2: every FAS followed by NFAS with second bit 0
    do_reset();
    mode = 1; never_mode = 1; never_tag = "R2 no lock after bad NFAS bit"; cmask = 0;
    run(19, 0);
    // R4: good NFAS but wrong FAS two frames on
    do_reset();
    mode = 2; never_mode = 1; never_tag = "R4 no lock after bad second FAS";
    run(19, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule